// File: doc/BRIEF.md
# Serial Register Access Interface

This block is the register side of a sampling converter's serial port. An external host drives a shift clock, an active-low frame select and a serial data line. Each frame is 16 bits long. The block shifts in the incoming word and, once the frame closes with exactly 16 bits received, decodes the two leading bits as a target address. It then commits the remaining 14 bits to one of three places: a control register, a test register, or a bank of calibration coefficients. On the same frame it shifts out one 16-bit word, most significant bit first. That word is chosen by sticky read-select bits that live in the control register.

The host's shift clock, frame select and data are brought into the core clock domain by synchronizer stages. A polarity input picks the idle level of the shift clock, and with it the edge on which data is sampled. The calibration bank is reached through a sub-address held in the control register. A run of DAC coefficient words in that bank is walked by an internal pointer that steps after each access.

Top module: `ser_reg_if`

## Requirements
- R1: After reset the control and test registers and all calibration registers are zero. `sdo` is 0, and the first frame reads `{2'b00, adc_data}`.
- R2: Bits 15:14 of a frame are the address and bits 13:0 are the data, sent MSB first. Address 11 writes the control register with bits 13:10 forced to zero. Address 01 writes the test register. Address 10 writes the calibration bank. Address 00 changes no register.
- R3: A frame commits only when the select rises after exactly 16 sample edges. A frame with fewer or more edges changes no register.
- R4: Control bits 7:6 choose the read word. 00 gives `{2'b00, adc_data}`, 01 gives `{2'b00, test}`, 10 gives `{2'b00, calibration word}` and 11 gives `status_word`. The choice stays in force until the control register is rewritten.
- R5: The read word is captured when the select falls and is shifted out MSB first. While the select is high, `sdo` is 0. A control write in a frame takes effect from the next frame.
- R6: Control bits 2:1 pick the calibration register: 01 offset, 10 gain, 11 reserved (writes dropped, reads zero), 00 a DAC word at the pointer. The pointer steps by one after each complete frame that writes sub-address 00, or that reads it with read select 10. It wraps from DAC_WORDS-1 to 0 and returns to 0 on any control write.
- R7: While control bit 0 is 1, calibration writes are dropped, calibration reads return zero and the pointer does not move.
- R8: Control bit 5 clears after every complete frame, unless that frame writes the control register with bit 5 set.
- R9: With `sclk_pol` = 0 the clock idles low, samples on rising edges and launches on falling edges. With `sclk_pol` = 1 all of this is reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_pol | input | 1 | Shift clock idle level / edge select |
| sclk | input | 1 | Host shift clock |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| adc_data | input | 14 | Latest conversion result |
| status_word | input | 16 | Status word for read select 11 |
| ctrl_q | output | 14 | Current control register |
| test_q | output | 14 | Current test register |

## Verification
Frames with every address, read select and calibration sub-address are driven under both clock polarities. Comparing the read word against the written values separates the four read sources and the four bank slots. Runs of DAC-word frames show pointer stepping, wrap and reset after a control write. Truncated and over-long frames show that nothing commits unless exactly 16 edges arrive. Frames with the start-calibration bit set show that the bank is locked. Frames written with and without mode bit 5 show when it self-clears.

// File: rtl/ser_reg_if_pkg.sv
package ser_reg_if_pkg;
   localparam int FRAME_W = 16;
   localparam int ADDR_W  = 2;
   localparam int DATA_W  = FRAME_W - ADDR_W;

   localparam int F_CALGO   = 0;
   localparam int F_CSUB_LO = 1;
   localparam int F_MODE    = 5;
   localparam int F_RSEL_LO = 6;
   localparam int F_ZERO_LO = 10;
   localparam int F_ZERO_HI = 13;

   typedef enum logic [1:0] {
      WA_NONE = 2'b00,
      WA_TEST = 2'b01,
      WA_CAL  = 2'b10,
      WA_CTRL = 2'b11
   } wr_addr_e;

   typedef enum logic [1:0] {
      RS_ADC  = 2'b00,
      RS_TEST = 2'b01,
      RS_CAL  = 2'b10,
      RS_STAT = 2'b11
   } rd_sel_e;

   typedef enum logic [1:0] {
      CB_DAC  = 2'b00,
      CB_OFFS = 2'b01,
      CB_GAIN = 2'b10,
      CB_RSVD = 2'b11
   } cal_sub_e;
endpackage

// File: rtl/ser_reg_if_sync.sv
module ser_reg_if_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ser_reg_if_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[g] <= RST_VAL;
         end else if (g == 0) begin
            stage_q[g] <= d;
         end else begin
            stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ser_reg_if_frame.sv
module ser_reg_if_frame #(
   parameter int FW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pol,
   input  logic          sclk_s,
   input  logic          csn_s,
   input  logic          sdi_s,
   input  logic [FW-1:0] rd_word,
   output logic          frame_start,
   output logic          commit,
   output logic [FW-1:0] rx_word,
   output logic          sdo
);
   localparam int CNT_W   = $clog2(FW + 2);
   localparam int CNT_TOP = FW + 1;

   if (FW < 4) begin : g_bad_fw
      $error("ser_reg_if_frame: FW too small");
   end

   logic             sclk_d, csn_d;
   logic [FW-1:0]    sh_in, sh_out;
   logic [CNT_W-1:0] cnt;
   logic             active, rise, fall, sample, launch, frame_end;

   assign active      = ~csn_s;
   assign rise        = sclk_s & ~sclk_d;
   assign fall        = ~sclk_s & sclk_d;
   assign sample      = active & (pol ? fall : rise);
   assign launch      = active & (pol ? rise : fall);
   assign frame_start = csn_d & ~csn_s;
   assign frame_end   = ~csn_d & csn_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         csn_d  <= 1'b1;
         sh_in  <= '0;
         sh_out <= '0;
         cnt    <= '0;
         commit <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         csn_d  <= csn_s;
         commit <= frame_end && (cnt == CNT_W'(FW));
         if (frame_start) begin
            sh_out <= rd_word;
            cnt    <= '0;
         end else begin
            if (sample) begin
               sh_in <= {sh_in[FW-2:0], sdi_s};
               if (cnt != CNT_W'(CNT_TOP)) begin
                  cnt <= cnt + 1'b1;
               end
            end
            if (launch) begin
               sh_out <= {sh_out[FW-2:0], 1'b0};
            end
         end
      end
   end

   assign rx_word = sh_in;
   assign sdo     = active & sh_out[FW-1];
endmodule

// File: rtl/ser_reg_if_regs.sv
module ser_reg_if_regs
   import ser_reg_if_pkg::*;
#(
   parameter int DW        = 14,
   parameter int FW        = 16,
   parameter int DAC_WORDS = 8,
   localparam int PTR_W    = (DAC_WORDS > 1) ? $clog2(DAC_WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [1:0]       addr,
   input  logic [DW-1:0]    data,
   input  logic [DW-1:0]    adc_data,
   input  logic [FW-1:0]    status_word,
   output logic [DW-1:0]    ctrl_q,
   output logic [DW-1:0]    test_q,
   output logic [FW-1:0]    rd_word,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(DAC_WORDS - 1);
   localparam logic [DW-1:0]    KEEP_MASK = DW'((1 << F_ZERO_LO) - 1);
   localparam int               PAD_W     = FW - DW;

   if (DW < F_ZERO_HI + 1) begin : g_bad_dw
      $error("ser_reg_if_regs: data field narrower than control layout");
   end
   if (DAC_WORDS < 1) begin : g_bad_dac
      $error("ser_reg_if_regs: DAC_WORDS must be at least 1");
   end

   logic [DW-1:0] offs_q, gain_q, cal_rd;
   logic [DW-1:0] dac_q [DAC_WORDS];
   logic          cal_open, wr_ctrl, wr_test, wr_cal, dac_step;
   cal_sub_e      sub;
   rd_sel_e       rsel;

   assign sub      = cal_sub_e'(ctrl_q[F_CSUB_LO +: 2]);
   assign rsel     = rd_sel_e'(ctrl_q[F_RSEL_LO +: 2]);
   assign cal_open = ~ctrl_q[F_CALGO];
   assign wr_ctrl  = commit && (wr_addr_e'(addr) == WA_CTRL);
   assign wr_test  = commit && (wr_addr_e'(addr) == WA_TEST);
   assign wr_cal   = commit && (wr_addr_e'(addr) == WA_CAL) && cal_open;
   assign dac_step = commit && !wr_ctrl && cal_open && (sub == CB_DAC) &&
                     ((wr_addr_e'(addr) == WA_CAL) || (rsel == RS_CAL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= data & KEEP_MASK;
      end else if (commit) begin
         ctrl_q[F_MODE] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         test_q <= '0;
      end else if (wr_test) begin
         test_q <= data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offs_q <= '0;
         gain_q <= '0;
      end else if (wr_cal) begin
         if (sub == CB_OFFS) offs_q <= data;
         if (sub == CB_GAIN) gain_q <= data;
      end
   end

   for (genvar g = 0; g < DAC_WORDS; g++) begin : g_dac
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dac_q[g] <= '0;
         end else if (wr_cal && (sub == CB_DAC) && (ptr == PTR_W'(g))) begin
            dac_q[g] <= data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (wr_ctrl) begin
         ptr <= '0;
      end else if (dac_step) begin
         ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
      end
   end

   always_comb begin
      cal_rd = '0;
      if (cal_open) begin
         unique case (sub)
            CB_DAC:  cal_rd = dac_q[ptr];
            CB_OFFS: cal_rd = offs_q;
            CB_GAIN: cal_rd = gain_q;
            CB_RSVD: cal_rd = '0;
         endcase
      end
   end

   always_comb begin
      unique case (rsel)
         RS_ADC:  rd_word = {{PAD_W{1'b0}}, adc_data};
         RS_TEST: rd_word = {{PAD_W{1'b0}}, test_q};
         RS_CAL:  rd_word = {{PAD_W{1'b0}}, cal_rd};
         RS_STAT: rd_word = status_word;
      endcase
   end
endmodule

// File: rtl/ser_reg_if.sv
module ser_reg_if
   import ser_reg_if_pkg::*;
#(
   parameter int FRAME_W     = ser_reg_if_pkg::FRAME_W,
   parameter int ADDR_W      = ser_reg_if_pkg::ADDR_W,
   parameter int DAC_WORDS   = 8,
   parameter int SYNC_STAGES = 2,
   localparam int DATA_W     = FRAME_W - ADDR_W,
   localparam int PTR_W      = (DAC_WORDS > 1) ? $clog2(DAC_WORDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_pol,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               sdi,
   output logic               sdo,
   input  logic [DATA_W-1:0]  adc_data,
   input  logic [FRAME_W-1:0] status_word,
   output logic [DATA_W-1:0]  ctrl_q,
   output logic [DATA_W-1:0]  test_q
);
   if (ADDR_W != 2) begin : g_bad_addr
      $error("ser_reg_if: address field must be 2 bits");
   end

   logic               sclk_s, csn_s, sdi_s;
   logic               frame_start, commit;
   logic [FRAME_W-1:0] rx_word, rd_word;
   logic [PTR_W-1:0]   ptr;

   ser_reg_if_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, cs_n, sdi}),
      .q     ({sclk_s, csn_s, sdi_s})
   );

   ser_reg_if_frame #(
      .FW (FRAME_W)
   ) frame_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pol         (sclk_pol),
      .sclk_s      (sclk_s),
      .csn_s       (csn_s),
      .sdi_s       (sdi_s),
      .rd_word     (rd_word),
      .frame_start (frame_start),
      .commit      (commit),
      .rx_word     (rx_word),
      .sdo         (sdo)
   );

   ser_reg_if_regs #(
      .DW        (DATA_W),
      .FW        (FRAME_W),
      .DAC_WORDS (DAC_WORDS)
   ) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit),
      .addr        (rx_word[FRAME_W-1 -: 2]),
      .data        (rx_word[DATA_W-1:0]),
      .adc_data    (adc_data),
      .status_word (status_word),
      .ctrl_q      (ctrl_q),
      .test_q      (test_q),
      .rd_word     (rd_word),
      .ptr         (ptr)
   );
endmodule

// File: rtl/ser_reg_if_chk.sv
module ser_reg_if_chk #(
   parameter int FW        = 16,
   parameter int DW        = 14,
   parameter int DAC_WORDS = 8,
   parameter int PW        = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          commit,
   input logic          frame_start,
   input logic [FW-1:0] rx_word,
   input logic [FW-1:0] rd_word,
   input logic          sdo,
   input logic [DW-1:0] ctrl_q,
   input logic [DW-1:0] test_q,
   input logic [PW-1:0] ptr
);
   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && rx_word[FW-1 -: 2] == 2'b11) |=>
         (ctrl_q == {4'b0000, $past(rx_word[9:0])}));

   assert_test_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && rx_word[FW-1 -: 2] == 2'b01) |=> (test_q == $past(rx_word[DW-1:0])));

   assert_hold_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(ctrl_q) && $stable(test_q)));

   assert_load_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (sdo == $past(rd_word[FW-1])));

   assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr) < DAC_WORDS);

   assert_ptr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && rx_word[FW-1 -: 2] == 2'b11) |=> (ptr == '0));

   assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && rx_word[FW-1 -: 2] != 2'b11) |=> !ctrl_q[5]);
endmodule

bind ser_reg_if ser_reg_if_chk #(
   .FW        (FRAME_W),
   .DW        (DATA_W),
   .DAC_WORDS (DAC_WORDS),
   .PW        (PTR_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .commit      (commit),
   .frame_start (frame_start),
   .rx_word     (rx_word),
   .rd_word     (rd_word),
   .sdo         (sdo),
   .ctrl_q      (ctrl_q),
   .test_q      (test_q),
   .ptr         (ptr)
);

// File: tb/ser_reg_if_tb_top.sv
module ser_reg_if_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int NDAC       = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pol = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        sdi = 1'b0;
   logic        sdo;
   logic [13:0] adc_data = 14'h0;
   logic [15:0] status_word = 16'h0;
   logic [13:0] ctrl_q, test_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [13:0] m_ctrl, m_test, m_off, m_gain;
   logic [13:0] m_dac [NDAC];
   int          m_ptr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ser_reg_if dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_pol(pol), .sclk(sclk), .cs_n(cs_n),
      .sdi(sdi), .sdo(sdo), .adc_data(adc_data), .status_word(status_word),
      .ctrl_q(ctrl_q), .test_q(test_q)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (HALF) @(negedge clk);
   endtask

   function automatic logic [13:0] cal_view();
      if (m_ctrl[0]) return 14'h0;
      case (m_ctrl[2:1])
         2'b00:   return m_dac[m_ptr];
         2'b01:   return m_off;
         2'b10:   return m_gain;
         default: return 14'h0;
      endcase
   endfunction

   function automatic logic [15:0] exp_read();
      case (m_ctrl[7:6])
         2'b00:   return {2'b00, adc_data};
         2'b01:   return {2'b00, m_test};
         2'b10:   return {2'b00, cal_view()};
         default: return status_word;
      endcase
   endfunction

   task automatic model_commit(input logic [15:0] w);
      logic [1:0]  a = w[15:14];
      logic [13:0] d = w[13:0];
      if (a == 2'b11) begin
         m_ctrl = {4'b0000, d[9:0]};
         m_ptr  = 0;
      end else begin
         if (!m_ctrl[0] && m_ctrl[2:1] == 2'b00 && (a == 2'b10 || m_ctrl[7:6] == 2'b10)) begin
            if (a == 2'b10) m_dac[m_ptr] = d;
            m_ptr = (m_ptr == NDAC-1) ? 0 : m_ptr + 1;
         end else if (a == 2'b10 && !m_ctrl[0]) begin
            if (m_ctrl[2:1] == 2'b01) m_off = d;
            if (m_ctrl[2:1] == 2'b10) m_gain = d;
         end
         if (a == 2'b01) m_test = d;
         m_ctrl[5] = 1'b0;
      end
   endtask

   task automatic set_pol(input logic v);
      @(negedge clk);
      pol  = v;
      sclk = v;
      repeat (8) @(negedge clk);
   endtask

   task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] r);
      r = 16'h0;
      @(negedge clk);
      cs_n = 1'b0;
      half();
      for (int i = 0; i < nb; i++) begin
         sdi = (i < 16) ? w[15-i] : 1'b0;
         half();
         if (i < 16) r[15-i] = sdo;
         sclk = ~pol;
         half();
         sclk = pol;
      end
      half();
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic run_frame(input logic [15:0] w, input int nb, input string rtag, input string wtag);
      logic [15:0] got, exp;
      exp = exp_read();
      xfer(w, nb, got);
      if (nb >= 16) chk(rtag, got, exp);
      if (nb == 16) model_commit(w);
      chk(wtag, {2'b00, ctrl_q}, {2'b00, m_ctrl});
      chk(wtag, {2'b00, test_q}, {2'b00, m_test});
      chk("R5 sdo idle", {15'h0, sdo}, 16'h0);
   endtask

   initial begin
      repeat (CLK_PERIOD * 200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] w;
      int          nb;
      string       rt;
      void'($urandom(32'd1234));
      m_ctrl = '0; m_test = '0; m_off = '0; m_gain = '0; m_ptr = 0;
      for (int i = 0; i < NDAC; i++) m_dac[i] = '0;
      adc_data    = 14'h2A5C;
      status_word = 16'hC3E1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      chk("R1 ctrl reset", {2'b00, ctrl_q}, 16'h0);
      chk("R1 test reset", {2'b00, test_q}, 16'h0);
      chk("R1 sdo reset", {15'h0, sdo}, 16'h0);

      run_frame(16'h1234, 16, "R1 default adc read", "R2 addr 00 ignored");
      run_frame({2'b01, 14'h3ABC}, 16, "R4 adc read", "R2 test write");
      run_frame({2'b11, 4'hF, 10'h0C0 | 10'h040}, 16, "R4 adc read", "R2 ctrl write zero bits");
      run_frame({2'b11, 14'h00C0}, 16, "R5 old select holds", "R2 ctrl write");
      run_frame(16'h0000, 16, "R4 status read", "R2 addr 00 ignored");
      run_frame({2'b11, 14'h0040}, 10, "R3 short", "R3 short frame dropped");
      run_frame({2'b01, 14'h0001}, 18, "R3 long", "R3 long frame dropped");
      run_frame({2'b11, 14'h0040}, 16, "R4 status read", "R2 ctrl write");
      run_frame(16'h0000, 16, "R4 test read", "R4 sticky");

      run_frame({2'b11, 14'h0080}, 16, "R4 test read", "R6 select dac");
      for (int i = 0; i < NDAC + 2; i++)
         run_frame({2'b10, 14'(16'h0100 + i * 16'h0111)}, 16, "R6 dac wrap read", "R6 dac write");
      for (int i = 0; i < NDAC; i++)
         run_frame(16'h0000, 16, "R6 dac read step", "R6 no write");
      run_frame({2'b11, 14'h0082}, 16, "R6 dac read", "R6 select offset");
      run_frame({2'b10, 14'h1357}, 16, "R6 offset read", "R6 offset write");
      run_frame({2'b11, 14'h0084}, 16, "R6 offset read", "R6 select gain");
      run_frame({2'b10, 14'h2468}, 16, "R6 gain read", "R6 gain write");
      run_frame({2'b11, 14'h0086}, 16, "R6 gain read", "R6 select reserved");
      run_frame({2'b10, 14'h3FFF}, 16, "R6 reserved reads zero", "R6 reserved write");
      run_frame({2'b11, 14'h0083}, 16, "R6 reserved reads zero", "R7 start cal set");
      run_frame({2'b10, 14'h0555}, 16, "R7 locked read zero", "R7 write dropped");
      run_frame({2'b11, 14'h0082}, 16, "R7 locked read zero", "R7 unlock");
      run_frame(16'h0000, 16, "R7 offset kept", "R7 unlock");

      run_frame({2'b11, 14'h0020}, 16, "R8 read", "R8 mode bit set");
      chk("R8 mode set", {15'h0, ctrl_q[5]}, 16'h1);
      run_frame(16'h0000, 16, "R8 read", "R8 mode cleared");
      chk("R8 mode cleared", {15'h0, ctrl_q[5]}, 16'h0);

      set_pol(1'b1);
      run_frame({2'b11, 14'h0040}, 16, "R9 pol1 read", "R9 pol1 ctrl write");
      run_frame({2'b01, 14'h1C3A}, 16, "R9 pol1 read", "R9 pol1 test write");
      run_frame(16'h0000, 16, "R9 pol1 test readback", "R9 pol1");
      set_pol(1'b0);

      for (int n = 0; n < 120; n++) begin
         if ($urandom_range(0, 5) == 0) set_pol(~pol);
         @(negedge clk);
         adc_data    = 14'($urandom);
         status_word = 16'($urandom);
         w = 16'($urandom);
         if (w[15:14] == 2'b11) w[0] = ($urandom_range(0, 5) == 0);
         nb = 16;
         if ($urandom_range(0, 9) == 0) nb = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 15) : 17;
         case (m_ctrl[7:6])
            2'b00:   rt = "R4 rand adc";
            2'b01:   rt = "R4 rand test";
            2'b10:   rt = m_ctrl[0] ? "R7 rand cal" : "R6 rand cal";
            default: rt = "R4 rand status";
         endcase
         run_frame(w, nb, rt, (nb == 16) ? "R2 rand write" : "R3 rand drop");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule